// File: doc/BRIEF.md
# CPU Run-Control Unit for Debug

This block gives an external debugger control over the execution of a small processor. A debug transport, which is not part of this block, reaches it through a narrow register bus with two addresses: a control register and a status register. From the control register the debugger can stop the CPU at an instruction boundary, let it run again, advance it by one instruction, freeze its peripherals, hold it in reset, arm software breakpoints and arm a halt that takes effect when reset is released.

The CPU side gives the block three signals. The first is a one-cycle strobe at every instruction boundary. The second flags a software breakpoint instruction. The third shows that the CPU's own power-up clear is active. The block turns the requests it receives into a halt request, a single-step window, a freeze level and a reset level toward the core. It keeps sticky cause flags that tell the debugger why the CPU stopped. The debugger clears those flags by writing ones to them.

Top module: `cpu_runctl`

## Requirements
- R1: After `rst_n` is asserted, both registers read 0x0000 and `cpu_halt_req`, `cpu_step_en`, `cpu_freeze` and `cpu_reset` are all 0.
- R2: The control register is at address 0 and the status register at address 1. Control bits 3 to 6 are stored and read back. Every other control bit, and every unused status bit, reads 0.
- R3: Writing control bit 0 (halt) asserts `cpu_halt_req` from the next cycle. Status bit 0 (halted) becomes 1 only in the cycle after a `cpu_boundary` strobe. While halted, `cpu_halt_req` stays 1 until a run or a step is granted.
- R4: Writing control bit 1 (run) clears the halted state and any pending halt. If bits 0 and 1 are written in the same access, halt wins.
- R5: While halted, writing control bit 2 (step) drops `cpu_halt_req` and raises `cpu_step_en` until the next `cpu_boundary`, and then returns to halted. A step write while running has no effect.
- R6: Status bit 0 cannot be changed by a status write. Writing 0x00FF to the status register while running still reads back 0x0000.
- R7: Control bit 6 drives `cpu_reset` for as long as it is set. Status bit 2 (reset seen) is set while the CPU is held in reset, whether by bit 6 or by `cpu_puc`. The bit stays set after release until a 1 is written to it.
- R8: With control bit 5 (break on reset) set, the end of a reset puts the CPU straight into the halted state with no instruction run, so the status reads 0x0005. Without bit 5 the CPU runs after reset.
- R9: When control bit 3 is set, a `cpu_swbrk` pulse halts the CPU and sets status bit 3. Writing 1 to bit 3 clears it and leaves the CPU halted. With bit 3 clear, the pulse has no effect. After a break-on-reset, a breakpoint hit reads 0x000D.
- R10: `cpu_freeze` follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address (0 control, 1 status) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| cpu_boundary | input | 1 | One-cycle strobe at each instruction boundary |
| cpu_swbrk | input | 1 | Software breakpoint instruction detected |
| cpu_puc | input | 1 | CPU power-up clear active |
| cpu_halt_req | output | 1 | Request to the CPU to stop at a boundary and stay stopped |
| cpu_step_en | output | 1 | Single-step window in progress |
| cpu_freeze | output | 1 | Peripheral freeze level |
| cpu_reset | output | 1 | Reset held on the CPU by the debugger |

## Verification
A corrupted run-state register shows up at the ports within one cycle. `cpu_halt_req` and `cpu_step_en` are decoded directly from it, and the halted status bit reads from it in the same cycle. A missed or extra boundary transition becomes visible as soon as the next status read after the strobe. A sticky flag that is lost or set by mistake stays visible on every later status read until it is cleared. For that reason every scenario reads the status both before and after each clear.

// File: rtl/cpu_runctl_pkg.sv
package cpu_runctl_pkg;
  typedef enum logic [1:0] {
    RC_RUN    = 2'd0,
    RC_HPEND  = 2'd1,
    RC_HALTED = 2'd2,
    RC_STEP   = 2'd3
  } rc_state_e;

  // control bit positions
  localparam int CB_HALT  = 0;
  localparam int CB_RUN   = 1;
  localparam int CB_STEP  = 2;
  localparam int CB_BRKEN = 3;
  localparam int CB_FRZ   = 4;
  localparam int CB_BOR   = 5;
  localparam int CB_RST   = 6;
  localparam int CB_LO    = CB_BRKEN;
  localparam int CB_NPER  = CB_RST - CB_BRKEN + 1;

  // status bit positions
  localparam int SB_HALTED = 0;
  localparam int SB_RST    = 2;
  localparam int SB_BRK    = 3;
endpackage

// File: rtl/cpu_runctl_ctl.sv
module cpu_runctl_ctl
  import cpu_runctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CB_RST:0]   wdata,
  output logic [CB_NPER-1:0] persist,
  output logic              req_halt,
  output logic              req_run,
  output logic              req_step
);
  logic [CB_NPER-1:0] persist_d;

  always_comb begin
    persist_d = persist;
    if (wr_en) persist_d = wdata[CB_RST:CB_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) persist <= '0;
    else if (wr_en) persist <= persist_d;
  end

  assign req_halt = wr_en & wdata[CB_HALT];
  assign req_run  = wr_en & wdata[CB_RUN];
  assign req_step = wr_en & wdata[CB_STEP];
endmodule

// File: rtl/cpu_runctl_fsm.sv
module cpu_runctl_fsm
  import cpu_runctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_eff,
  input  logic      rst_release,
  input  logic      bor_en,
  input  logic      brk_hit,
  input  logic      req_halt,
  input  logic      req_run,
  input  logic      req_step,
  input  logic      boundary,
  output rc_state_e state
);
  rc_state_e state_d;
  logic      in_flight;

  assign in_flight = (state == RC_HPEND) || (state == RC_STEP);

  always_comb begin
    state_d = state;
    if (rst_eff)
      state_d = RC_RUN;
    else if (rst_release)
      state_d = bor_en ? RC_HALTED : RC_RUN;
    else if (brk_hit)
      state_d = RC_HALTED;
    else if (req_halt)
      state_d = (state == RC_HALTED || boundary) ? RC_HALTED : RC_HPEND;
    else if (req_run)
      state_d = RC_RUN;
    else if (req_step && state == RC_HALTED)
      state_d = RC_STEP;
    else if (boundary && in_flight)
      state_d = RC_HALTED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RC_RUN;
    else        state <= state_d;
  end
endmodule

// File: rtl/cpu_runctl_flags.sv
module cpu_runctl_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_rst,
  input  logic set_brk,
  input  logic clr_rst,
  input  logic clr_brk,
  output logic rst_flag,
  output logic brk_flag
);
  logic rst_flag_d, brk_flag_d;

  // a set in the same cycle as a clear wins
  always_comb begin
    rst_flag_d = set_rst | (rst_flag & ~clr_rst);
    brk_flag_d = set_brk | (brk_flag & ~clr_brk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_flag <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      rst_flag <= rst_flag_d;
      brk_flag <= brk_flag_d;
    end
  end
endmodule

// File: rtl/cpu_runctl.sv
module cpu_runctl
  import cpu_runctl_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 1,
  parameter int CTL_ADDR  = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cpu_boundary,
  input  logic          cpu_swbrk,
  input  logic          cpu_puc,
  output logic          cpu_halt_req,
  output logic          cpu_step_en,
  output logic          cpu_freeze,
  output logic          cpu_reset
);
  localparam logic [AW-1:0] A_CTL  = AW'(CTL_ADDR);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);

  logic               ctl_wr, stat_wr;
  logic [CB_NPER-1:0] persist;
  logic               req_halt, req_run, req_step;
  logic               brk_en, bor_en;
  logic               rst_eff, rst_eff_q, rst_release, brk_hit;
  logic               rst_flag, brk_flag, st_halted;
  rc_state_e          state;

  assign ctl_wr  = bus_wr && (bus_addr == A_CTL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  cpu_runctl_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr),
    .wdata    (bus_wdata[CB_RST:0]),
    .persist  (persist),
    .req_halt (req_halt),
    .req_run  (req_run),
    .req_step (req_step)
  );

  assign brk_en     = persist[CB_BRKEN-CB_LO];
  assign bor_en     = persist[CB_BOR-CB_LO];
  assign cpu_freeze = persist[CB_FRZ-CB_LO];
  assign cpu_reset  = persist[CB_RST-CB_LO];

  assign rst_eff = cpu_reset | cpu_puc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_eff_q <= 1'b0;
    else        rst_eff_q <= rst_eff;
  end

  assign rst_release = rst_eff_q & ~rst_eff;
  assign brk_hit     = cpu_swbrk & brk_en & ~rst_eff;

  cpu_runctl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_eff     (rst_eff),
    .rst_release (rst_release),
    .bor_en      (bor_en),
    .brk_hit     (brk_hit),
    .req_halt    (req_halt),
    .req_run     (req_run),
    .req_step    (req_step),
    .boundary    (cpu_boundary),
    .state       (state)
  );

  cpu_runctl_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_rst  (rst_eff),
    .set_brk  (brk_hit),
    .clr_rst  (stat_wr & bus_wdata[SB_RST]),
    .clr_brk  (stat_wr & bus_wdata[SB_BRK]),
    .rst_flag (rst_flag),
    .brk_flag (brk_flag)
  );

  assign st_halted    = (state == RC_HALTED);
  assign cpu_halt_req = (state == RC_HALTED) || (state == RC_HPEND);
  assign cpu_step_en  = (state == RC_STEP);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTL) begin
      bus_rdata[CB_RST:CB_LO] = persist;
    end else if (bus_addr == A_STAT) begin
      bus_rdata[SB_HALTED] = st_halted;
      bus_rdata[SB_RST]    = rst_flag;
      bus_rdata[SB_BRK]    = brk_flag;
    end
  end
endmodule

// File: rtl/cpu_runctl_chk.sv
module cpu_runctl_chk #(
  parameter int DW        = 16,
  parameter int AW        = 1,
  parameter int CTL_ADDR  = 0,
  parameter int STAT_ADDR = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          cpu_halt_req,
  input logic          cpu_step_en,
  input logic          cpu_reset,
  input logic          cpu_puc,
  input logic          st_halted,
  input logic          rst_flag,
  input logic          brk_flag
);
  logic ctl_wr, stat_wr;
  assign ctl_wr  = bus_wr && (bus_addr == AW'(CTL_ADDR));
  assign stat_wr = bus_wr && (bus_addr == AW'(STAT_ADDR));

  AST_HALTED_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    st_halted |-> cpu_halt_req) else $error("halted without halt request"); // R3

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt_req && !(ctl_wr && (bus_wdata[1] || bus_wdata[2])) && !cpu_reset && !cpu_puc)
    |=> cpu_halt_req) else $error("halt dropped without run or step"); // R4

  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_step_en && cpu_halt_req)) else $error("step and halt together"); // R5

  AST_STEP_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_step_en) |-> $past(st_halted)) else $error("step granted while not halted"); // R5

  AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |=> rst_flag) else $error("reset flag not set"); // R7

  AST_RST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flag && !(stat_wr && bus_wdata[2])) |=> rst_flag) else $error("reset flag lost"); // R7

  AST_BRK_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !(stat_wr && bus_wdata[3])) |=> brk_flag) else $error("break flag lost"); // R9
endmodule

bind cpu_runctl cpu_runctl_chk #(
  .DW(DW), .AW(AW), .CTL_ADDR(CTL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .cpu_halt_req (cpu_halt_req),
  .cpu_step_en  (cpu_step_en),
  .cpu_reset    (cpu_reset),
  .cpu_puc      (cpu_puc),
  .st_halted    (st_halted),
  .rst_flag     (rst_flag),
  .brk_flag     (brk_flag)
);

// File: tb/cpu_runctl_bench.sv
module cpu_runctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [0:0]  bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_boundary = 1'b0;
  logic        cpu_swbrk = 1'b0;
  logic        cpu_puc = 1'b0;
  logic        cpu_halt_req, cpu_step_en, cpu_freeze, cpu_reset;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  localparam logic CTL = 1'b0;
  localparam logic STA = 1'b1;

  // control write value, expected readback
  localparam logic [31:0] VEC [6] = '{
    {16'h0008, 16'h0008},
    {16'h0010, 16'h0010},
    {16'h0020, 16'h0020},
    {16'h0038, 16'h0038},
    {16'hFF30, 16'h0030},
    {16'h0000, 16'h0000}
  };

  always #5 clk = ~clk;

  cpu_runctl u_cpu_runctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .cpu_boundary (cpu_boundary),
    .cpu_swbrk    (cpu_swbrk),
    .cpu_puc      (cpu_puc),
    .cpu_halt_req (cpu_halt_req),
    .cpu_step_en  (cpu_step_en),
    .cpu_freeze   (cpu_freeze),
    .cpu_reset    (cpu_reset)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_boundary();
    @(negedge clk); cpu_boundary = 1'b1;
    @(negedge clk); cpu_boundary = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); cpu_swbrk = 1'b1;
    @(negedge clk); cpu_swbrk = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(STA, d); chk("R1 status", d, 16'h0000);
    rd(CTL, d); chk("R1 control", d, 16'h0000);
    chk("R1 outputs", {12'h0, cpu_halt_req, cpu_step_en, cpu_freeze, cpu_reset}, 16'h0000);

    // R2 / R10 table
    for (int i = 0; i < 6; i++) begin
      wr(CTL, VEC[i][31:16]);
      rd(CTL, d); chk("R2 readback", d, VEC[i][15:0]);
      chk("R10 freeze", {15'h0, cpu_freeze}, {15'h0, VEC[i][4]});
    end

    // R6 halted bit not writable
    wr(STA, 16'h00FF);
    rd(STA, d); chk("R6 status write", d, 16'h0000);

    // R3 halt at boundary
    wr(CTL, 16'h0001);
    chk("R3 halt req", {15'h0, cpu_halt_req}, 16'h0001);
    rd(STA, d); chk("R3 pending not halted", d, 16'h0000);
    pulse_boundary();
    rd(STA, d); chk("R3 halted", d, 16'h0001);
    idle(5);
    chk("R3 halt held", {15'h0, cpu_halt_req}, 16'h0001);

    // R10 freeze while halted
    wr(CTL, 16'h0010);
    chk("R10 freeze on", {15'h0, cpu_freeze}, 16'h0001);
    wr(CTL, 16'h0000);
    chk("R10 freeze off", {15'h0, cpu_freeze}, 16'h0000);

    // R5 single steps
    for (int s = 0; s < 2; s++) begin
      wr(CTL, 16'h0004);
      chk("R5 step window", {14'h0, cpu_step_en, cpu_halt_req}, 16'h0002);
      rd(STA, d); chk("R5 not halted while stepping", d, 16'h0000);
      pulse_boundary();
      rd(STA, d); chk("R5 back to halt", d, 16'h0001);
      chk("R5 outputs after step", {14'h0, cpu_step_en, cpu_halt_req}, 16'h0001);
    end

    // R4 halt wins over run, then run
    wr(CTL, 16'h0003);
    rd(STA, d); chk("R4 halt priority", d, 16'h0001);
    wr(CTL, 16'h0002);
    rd(STA, d); chk("R4 run", d, 16'h0000);
    chk("R4 halt released", {15'h0, cpu_halt_req}, 16'h0000);

    // R5 step ignored while running
    wr(CTL, 16'h0004);
    chk("R5 step ignored", {14'h0, cpu_step_en, cpu_halt_req}, 16'h0000);
    rd(STA, d); chk("R5 step ignored status", d, 16'h0000);

    // R4 run cancels pending halt
    wr(CTL, 16'h0001);
    wr(CTL, 16'h0002);
    chk("R4 pending cancelled", {15'h0, cpu_halt_req}, 16'h0000);

    // R7 reset via control
    wr(CTL, 16'h0040);
    idle(2);
    chk("R7 reset out", {15'h0, cpu_reset}, 16'h0001);
    rd(STA, d); chk("R7 reset flag", d, 16'h0004);
    wr(CTL, 16'h0000);
    idle(3);
    chk("R7 reset released", {15'h0, cpu_reset}, 16'h0000);
    rd(STA, d); chk("R7 flag sticky, running", d, 16'h0004);
    wr(STA, 16'h0004);
    rd(STA, d); chk("R7 flag cleared", d, 16'h0000);

    // R8 break on reset
    wr(CTL, 16'h0060);
    idle(2);
    rd(STA, d); chk("R8 in reset", d, 16'h0004);
    wr(CTL, 16'h0020);
    idle(3);
    rd(STA, d); chk("R8 halted on release", d, 16'h0005);
    pulse_boundary();
    rd(STA, d); chk("R8 stays halted", d, 16'h0005);
    wr(STA, 16'h0004);
    rd(STA, d); chk("R8 clear keeps halt", d, 16'h0001);
    wr(CTL, 16'h0002);
    rd(STA, d); chk("R8 run", d, 16'h0000);

    // R8 power-up clear with break on reset
    wr(CTL, 16'h0020);
    @(negedge clk); cpu_puc = 1'b1;
    idle(2); cpu_puc = 1'b0;
    idle(3);
    rd(STA, d); chk("R8 puc release halts", d, 16'h0005);
    wr(STA, 16'h0004);
    wr(CTL, 16'h0002);
    rd(STA, d); chk("R8 puc run", d, 16'h0000);

    // R9 software breakpoint
    wr(CTL, 16'h0008);
    pulse_brk();
    rd(STA, d); chk("R9 break hit", d, 16'h0009);
    chk("R9 halt req", {15'h0, cpu_halt_req}, 16'h0001);
    wr(STA, 16'h0008);
    rd(STA, d); chk("R9 clear keeps halt", d, 16'h0001);
    wr(CTL, 16'h000A);
    rd(STA, d); chk("R9 run", d, 16'h0000);
    wr(CTL, 16'h0002);
    pulse_brk();
    rd(STA, d); chk("R9 disabled ignored", d, 16'h0000);

    // R9 combined flags
    wr(CTL, 16'h0068);
    idle(2);
    wr(CTL, 16'h0028);
    idle(3);
    rd(STA, d); chk("R9 bor halt", d, 16'h0005);
    wr(CTL, 16'h002A);
    pulse_brk();
    rd(STA, d); chk("R9 combined", d, 16'h000D);
    wr(STA, 16'h000C);
    rd(STA, d); chk("R9 combined clear", d, 16'h0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule